// File: doc/BRIEF.md
# Single-Lane Structure Store Sequencer

This block carries out the store of one structure of one to four elements. Every element comes from the same lane of a different 64-bit vector register. The registers in the list sit either next to each other or every second register apart. The elements are packed into memory one after another, in list order. A request names the element count, the element size, the lane, the first register, the spacing, an optional alignment hint, the base address and a base-update mode.

When the request is accepted, the block first judges the whole combination. An illegal combination, or a base address that does not meet a given hint, returns a one-cycle error pulse. In that case nothing is written and the base is not updated. A legal request is then carried out one element per write. The sequencer reads each register through a simple read port, picks out the lane and issues a byte-enabled write on a valid/ready memory port. When the last write has been taken, it pulses done and presents the updated base.

The sequencer holds one request at a time. Any request offered while it is working is ignored.

Top module: `lane_struct_store`

## Requirements
- R1: `req_count` holds n-1, so n is 1 to 4. `req_esize` is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit elements, and code 3 is illegal. `req_lane` must be below 8, 4 or 2 for those sizes. `req_stride2`=1 (spacing of two registers) is legal only for 16-bit or 32-bit elements with n of 2 or more. Any violation gives an error.
- R2: The last register, `req_first_reg` + (n-1)×spacing, must be at most 31. Otherwise the request gives an error.
- R3: `req_align` is 0 for no hint, 1 for 2 bytes, 2 for 4, 3 for 8 and 4 for 16; codes 5 to 7 are illegal. A hint is legal only when it equals n × element bytes, plus the extra case of 8 bytes when n=4 with 32-bit elements. With n=3 no hint is legal, and with n=1 and 8-bit elements no hint is legal.
- R4: With a hint present, a base address that is not a multiple of the hint gives an error. With no hint, the base is not checked.
- R5: `req_wb_mode` is 0 for no update, 1 for update by bytes stored and 2 for update by offset; code 3 is illegal. `req_base_reg`=15 is always illegal. In mode 2, `req_off_reg` of 13 or 15 is illegal.
- R6: An illegal request raises `err` for exactly one cycle, in the cycle after it was offered. It issues no write, gives no `done`, does not set `busy`, and leaves `new_base` unchanged.
- R7: Element k is read from register first + k×spacing at the requested lane and written to address base + k×element bytes. The element sits in the low bytes of `mem_wr_data`, and the upper bytes are zero. `mem_wr_be` is 0001, 0011 or 1111 for the three sizes.
- R8: While `mem_wr_valid` is high and `mem_wr_ready` is low, the address, data and byte enables of the write stay unchanged.
- R9: `done` is high for one cycle, in the cycle after the last write is accepted. `new_base` is then the base for mode 0, the base plus n×element bytes for mode 1, and the base plus `req_offset` (modulo 2^32) for mode 2. `new_base` holds that value until the next `done`.
- R10: `busy` is high from the cycle after a legal request is accepted until the last write is accepted. A request offered while busy is ignored and causes neither an error nor a change to the write in progress.
- R11: A request offered in the same cycle as `done` is accepted, whether it is legal or illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_count | input | 2 | Element count minus one |
| req_esize | input | 2 | Element size code |
| req_lane | input | 3 | Lane index |
| req_first_reg | input | 5 | First vector register |
| req_stride2 | input | 1 | Register spacing of two |
| req_align | input | 3 | Alignment hint code |
| req_base_reg | input | 4 | Index of the scalar register holding the base |
| req_wb_mode | input | 2 | Base update mode |
| req_off_reg | input | 4 | Index of the scalar register holding the offset |
| req_base | input | 32 | Base address |
| req_offset | input | 32 | Offset value for mode 2 |
| busy | output | 1 | Request in progress |
| rf_rd_idx | output | 5 | Vector register read index |
| rf_rd_data | input | 64 | Vector register read data, same cycle |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | 32 | Byte address of the write |
| mem_wr_data | output | 32 | Element, low-justified |
| mem_wr_be | output | 4 | Byte enables |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle error pulse |
| new_base | output | 32 | Updated base address |

## Verification
There are two ways the block can have two of its functions active in the same cycle.

The first is completion and a new request. The cycle that carries `done` and presents the new base is also a cycle in which the sequencer is idle and can take the next request. The bench offers a second legal request in exactly the `done` cycle and checks that both writeback values and both write streams are correct. It then offers an illegal request in the next `done` cycle and checks that `err` follows one cycle later with no write.

The second is a stalled write and an incoming request. The bench keeps `mem_wr_ready` low while an illegal request is held on the request port. It checks that the stalled write stays unchanged and that no error appears.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [1:0] {
      ESZ_B8   = 2'd0,
      ESZ_B16  = 2'd1,
      ESZ_B32  = 2'd2,
      ESZ_RSVD = 2'd3
   } esz_e;

   typedef enum logic [1:0] {
      WB_OFF  = 2'd0,
      WB_IMM  = 2'd1,
      WB_REG  = 2'd2,
      WB_RSVD = 2'd3
   } wb_e;

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_WRITE = 1'b1
   } seq_e;

   localparam logic [3:0] GPR_SP = 4'd13;
   localparam logic [3:0] GPR_PC = 4'd15;
   localparam int unsigned ELEM_W = 32;
   localparam int unsigned ELEM_B = ELEM_W / 8;

   function automatic logic [2:0] elem_bytes(input logic [1:0] code);
      case (code)
         ESZ_B8:  return 3'd1;
         ESZ_B16: return 3'd2;
         ESZ_B32: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [4:0] hint_bytes(input logic [2:0] code);
      case (code)
         3'd1:    return 5'd2;
         3'd2:    return 5'd4;
         3'd3:    return 5'd8;
         3'd4:    return 5'd16;
         default: return 5'd0;
      endcase
   endfunction

   function automatic logic [ELEM_B-1:0] byte_mask(input logic [1:0] code);
      case (code)
         ESZ_B8:  return ELEM_B'(4'b0001);
         ESZ_B16: return ELEM_B'(4'b0011);
         default: return ELEM_B'(4'b1111);
      endcase
   endfunction

endpackage

// File: rtl/lss_legality.sv
module lss_legality
   import lss_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int REG_W     = 64,
   parameter int NUM_REGS  = 32,
   parameter int REG_IDX_W = 5,
   parameter int LANE_W    = 3
) (
   input  logic [1:0]           count,
   input  logic [1:0]           esize,
   input  logic [LANE_W-1:0]    lane,
   input  logic [REG_IDX_W-1:0] first_reg,
   input  logic                 stride2,
   input  logic [2:0]           align,
   input  logic [3:0]           base_reg,
   input  logic [1:0]           wb_mode,
   input  logic [3:0]           off_reg,
   input  logic [ADDR_W-1:0]    base,
   output logic                 legal
);

   localparam int LW1 = LANE_W + 1;
   localparam int RW3 = REG_IDX_W + 3;

   logic [2:0]        eb;
   logic [4:0]        tot_b;
   logic [4:0]        hint_b;
   logic [LW1-1:0]    lanes_avail;
   logic [RW3-1:0]    last_reg;
   logic [ADDR_W-1:0] align_mask;

   logic size_ok, lane_ok, stride_ok, range_ok;
   logic hint_ok, base_ok, gpr_ok;

   assign eb          = elem_bytes(esize);
   assign tot_b       = (5'(count) + 5'd1) * 5'(eb);
   assign hint_b      = hint_bytes(align);
   assign lanes_avail = LW1'(REG_W / 8) >> esize;
   assign last_reg    = RW3'(first_reg) +
                        (stride2 ? RW3'({count, 1'b0}) : RW3'(count));
   assign align_mask  = ADDR_W'(hint_b) - ADDR_W'(1);

   assign size_ok   = (esize != ESZ_RSVD);
   assign lane_ok   = ({1'b0, lane} < lanes_avail);
   assign stride_ok = !stride2 || ((esize != ESZ_B8) && (count != 2'd0));
   assign range_ok  = (last_reg < RW3'(NUM_REGS));

   always_comb begin
      hint_ok = 1'b1;
      if (align > 3'd4) begin
         hint_ok = 1'b0;
      end else if (align != 3'd0) begin
         if (count == 2'd2) begin
            hint_ok = 1'b0;
         end else begin
            hint_ok = (hint_b == tot_b) ||
                      ((count == 2'd3) && (esize == ESZ_B32) && (hint_b == 5'd8));
         end
      end
   end

   assign base_ok = (align == 3'd0) || ((base & align_mask) == '0);

   assign gpr_ok = (base_reg != GPR_PC) && (wb_mode != WB_RSVD) &&
                   !((wb_mode == WB_REG) && ((off_reg == GPR_SP) || (off_reg == GPR_PC)));

   assign legal = size_ok && lane_ok && stride_ok && range_ok &&
                  hint_ok && base_ok && gpr_ok;

endmodule

// File: rtl/lss_lane_pick.sv
module lss_lane_pick
   import lss_pkg::*;
#(
   parameter int REG_W  = 64,
   parameter int LANE_W = 3
) (
   input  logic [REG_W-1:0]  reg_data,
   input  logic [1:0]        esize,
   input  logic [LANE_W-1:0] lane,
   output logic [ELEM_W-1:0] elem,
   output logic [ELEM_B-1:0] be
);

   logic [ELEM_W-1:0] pick [3];

   for (genvar s = 0; s < 3; s++) begin : g_size
      localparam int EW = 8 << s;
      localparam int NL = REG_W / EW;
      localparam int IW = $clog2(NL);
      logic [EW-1:0] slice [NL];
      for (genvar l = 0; l < NL; l++) begin : g_lane
         assign slice[l] = reg_data[l*EW +: EW];
      end
      assign pick[s] = ELEM_W'(slice[lane[IW-1:0]]);
   end

   always_comb begin
      case (esize)
         ESZ_B8:  elem = pick[0];
         ESZ_B16: elem = pick[1];
         default: elem = pick[2];
      endcase
   end

   assign be = byte_mask(esize);

endmodule

// File: rtl/lss_sequencer.sv
module lss_sequencer
   import lss_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int REG_IDX_W = 5,
   parameter int LANE_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 legal,
   input  logic [1:0]           count,
   input  logic [1:0]           esize,
   input  logic [LANE_W-1:0]    lane,
   input  logic [REG_IDX_W-1:0] first_reg,
   input  logic                 stride2,
   input  logic [1:0]           wb_mode,
   input  logic [ADDR_W-1:0]    base,
   input  logic [ADDR_W-1:0]    offset,
   input  logic                 wr_ready,
   output logic                 busy,
   output logic [REG_IDX_W-1:0] rd_idx,
   output logic [1:0]           esize_q,
   output logic [LANE_W-1:0]    lane_q,
   output logic                 wr_valid,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic                 done,
   output logic                 err,
   output logic [ADDR_W-1:0]    new_base
);

   seq_e                 state_q;
   logic [1:0]           last_q;
   logic [1:0]           k_q;
   logic [REG_IDX_W-1:0] first_q;
   logic                 stride2_q;
   logic [1:0]           wb_q;
   logic [ADDR_W-1:0]    base_q;
   logic [ADDR_W-1:0]    offset_q;
   logic [ADDR_W-1:0]    addr_q;
   logic                 done_q;
   logic                 err_q;
   logic [ADDR_W-1:0]    nb_q;

   logic [ADDR_W-1:0]    step;
   logic [ADDR_W-1:0]    nb_next;
   logic                 take;
   logic                 last_beat;

   assign step      = ADDR_W'(elem_bytes(esize_q));
   assign take      = (state_q == SEQ_IDLE) && req_valid;
   assign last_beat = (state_q == SEQ_WRITE) && wr_ready && (k_q == last_q);

   always_comb begin
      case (wb_q)
         WB_IMM:  nb_next = addr_q + step;
         WB_REG:  nb_next = base_q + offset_q;
         default: nb_next = base_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         last_q    <= '0;
         k_q       <= '0;
         esize_q   <= '0;
         lane_q    <= '0;
         first_q   <= '0;
         stride2_q <= 1'b0;
         wb_q      <= '0;
         base_q    <= '0;
         offset_q  <= '0;
         addr_q    <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         nb_q      <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (take) begin
            if (legal) begin
               state_q   <= SEQ_WRITE;
               last_q    <= count;
               k_q       <= '0;
               esize_q   <= esize;
               lane_q    <= lane;
               first_q   <= first_reg;
               stride2_q <= stride2;
               wb_q      <= wb_mode;
               base_q    <= base;
               offset_q  <= offset;
               addr_q    <= base;
            end else begin
               err_q <= 1'b1;
            end
         end else if ((state_q == SEQ_WRITE) && wr_ready) begin
            if (last_beat) begin
               state_q <= SEQ_IDLE;
               done_q  <= 1'b1;
               nb_q    <= nb_next;
            end else begin
               k_q    <= k_q + 2'd1;
               addr_q <= addr_q + step;
            end
         end
      end
   end

   assign rd_idx   = first_q + (stride2_q ? REG_IDX_W'({k_q, 1'b0}) : REG_IDX_W'(k_q));
   assign busy     = (state_q == SEQ_WRITE);
   assign wr_valid = (state_q == SEQ_WRITE);
   assign wr_addr  = addr_q;
   assign done     = done_q;
   assign err      = err_q;
   assign new_base = nb_q;

endmodule

// File: rtl/lane_struct_store.sv
module lane_struct_store
   import lss_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int REG_W     = 64,
   parameter int NUM_REGS  = 32,
   parameter int REG_IDX_W = $clog2(NUM_REGS),
   parameter int LANE_W    = $clog2(REG_W / 8)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           req_count,
   input  logic [1:0]           req_esize,
   input  logic [LANE_W-1:0]    req_lane,
   input  logic [REG_IDX_W-1:0] req_first_reg,
   input  logic                 req_stride2,
   input  logic [2:0]           req_align,
   input  logic [3:0]           req_base_reg,
   input  logic [1:0]           req_wb_mode,
   input  logic [3:0]           req_off_reg,
   input  logic [ADDR_W-1:0]    req_base,
   input  logic [ADDR_W-1:0]    req_offset,
   output logic                 busy,
   output logic [REG_IDX_W-1:0] rf_rd_idx,
   input  logic [REG_W-1:0]     rf_rd_data,
   output logic                 mem_wr_valid,
   input  logic                 mem_wr_ready,
   output logic [ADDR_W-1:0]    mem_wr_addr,
   output logic [ELEM_W-1:0]    mem_wr_data,
   output logic [ELEM_B-1:0]    mem_wr_be,
   output logic                 done,
   output logic                 err,
   output logic [ADDR_W-1:0]    new_base
);

   if (REG_W < 64 || (REG_W & (REG_W - 1)) != 0) begin : g_bad_reg_w
      $error("lane_struct_store: REG_W must be a power of two of at least 64");
   end
   if (NUM_REGS < 4 || NUM_REGS > (1 << REG_IDX_W)) begin : g_bad_num_regs
      $error("lane_struct_store: NUM_REGS out of range for REG_IDX_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("lane_struct_store: ADDR_W must be at least 8");
   end

   logic              legal;
   logic [1:0]        esize_q;
   logic [LANE_W-1:0] lane_q;

   lss_legality #(
      .ADDR_W    (ADDR_W),
      .REG_W     (REG_W),
      .NUM_REGS  (NUM_REGS),
      .REG_IDX_W (REG_IDX_W),
      .LANE_W    (LANE_W)
   ) u_legal (
      .count     (req_count),
      .esize     (req_esize),
      .lane      (req_lane),
      .first_reg (req_first_reg),
      .stride2   (req_stride2),
      .align     (req_align),
      .base_reg  (req_base_reg),
      .wb_mode   (req_wb_mode),
      .off_reg   (req_off_reg),
      .base      (req_base),
      .legal     (legal)
   );

   lss_sequencer #(
      .ADDR_W    (ADDR_W),
      .REG_IDX_W (REG_IDX_W),
      .LANE_W    (LANE_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .legal     (legal),
      .count     (req_count),
      .esize     (req_esize),
      .lane      (req_lane),
      .first_reg (req_first_reg),
      .stride2   (req_stride2),
      .wb_mode   (req_wb_mode),
      .base      (req_base),
      .offset    (req_offset),
      .wr_ready  (mem_wr_ready),
      .busy      (busy),
      .rd_idx    (rf_rd_idx),
      .esize_q   (esize_q),
      .lane_q    (lane_q),
      .wr_valid  (mem_wr_valid),
      .wr_addr   (mem_wr_addr),
      .done      (done),
      .err       (err),
      .new_base  (new_base)
   );

   lss_lane_pick #(
      .REG_W  (REG_W),
      .LANE_W (LANE_W)
   ) u_pick (
      .reg_data (rf_rd_data),
      .esize    (esize_q),
      .lane     (lane_q),
      .elem     (mem_wr_data),
      .be       (mem_wr_be)
   );

endmodule

// File: rtl/lss_props.sv
module lss_props #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_wr_valid,
   input logic              mem_wr_ready,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [31:0]       mem_wr_data,
   input logic [3:0]        mem_wr_be,
   input logic              done,
   input logic              err,
   input logic [ADDR_W-1:0] new_base
);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_be)));

   // R7
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (mem_wr_be == 4'b0001 || mem_wr_be == 4'b0011 || mem_wr_be == 4'b1111));

   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && mem_wr_ready) |=>
         (!mem_wr_valid ||
          mem_wr_addr == $past(mem_wr_addr) + ADDR_W'($countones($past(mem_wr_be)))));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(new_base));

   // R6
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!mem_wr_valid && !done && !busy));

   // R10
   valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> busy);

endmodule

bind lane_struct_store lss_props #(.ADDR_W(ADDR_W)) u_props (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .mem_wr_valid (mem_wr_valid),
   .mem_wr_ready (mem_wr_ready),
   .mem_wr_addr  (mem_wr_addr),
   .mem_wr_data  (mem_wr_data),
   .mem_wr_be    (mem_wr_be),
   .done         (done),
   .err          (err),
   .new_base     (new_base)
);

// File: tb/lane_struct_store_test.sv
module lane_struct_store_test;

   typedef struct packed {
      logic [1:0]  cnt;
      logic [1:0]  esz;
      logic [2:0]  lane;
      logic [4:0]  first;
      logic        s2;
      logic [2:0]  al;
      logic [3:0]  breg;
      logic [1:0]  wb;
      logic [3:0]  oreg;
      logic [31:0] base;
      logic [31:0] off;
      logic        xerr;
      logic [31:0] xnb;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [0:NV-1] = '{
      '{2'd0, 2'd0, 3'd5, 5'd3,  1'b0, 3'd0, 4'd2,  2'd1, 4'd0,  32'h1003, 32'h0, 1'b0, 32'h1004}, // R7 R9
      '{2'd1, 2'd1, 3'd2, 5'd10, 1'b1, 3'd2, 4'd2,  2'd2, 4'd4,  32'h2000, 32'h40, 1'b0, 32'h2040}, // R3 R9
      '{2'd2, 2'd2, 3'd1, 5'd29, 1'b0, 3'd0, 4'd2,  2'd0, 4'd0,  32'h3001, 32'h0, 1'b0, 32'h3001}, // R2 R4
      '{2'd3, 2'd2, 3'd0, 5'd20, 1'b1, 3'd4, 4'd2,  2'd1, 4'd0,  32'h4000, 32'h0, 1'b0, 32'h4010}, // R3
      '{2'd3, 2'd2, 3'd1, 5'd0,  1'b0, 3'd3, 4'd2,  2'd1, 4'd0,  32'h5008, 32'h0, 1'b0, 32'h5018}, // R3
      '{2'd3, 2'd0, 3'd7, 5'd28, 1'b0, 3'd2, 4'd2,  2'd1, 4'd0,  32'h6004, 32'h0, 1'b0, 32'h6008}, // R2
      '{2'd2, 2'd2, 3'd0, 5'd30, 1'b0, 3'd0, 4'd2,  2'd1, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R2
      '{2'd1, 2'd0, 3'd0, 5'd0,  1'b1, 3'd0, 4'd2,  2'd1, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R1 stride
      '{2'd2, 2'd1, 3'd0, 5'd0,  1'b0, 3'd2, 4'd2,  2'd1, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R3 n=3
      '{2'd1, 2'd2, 3'd0, 5'd0,  1'b0, 3'd3, 4'd2,  2'd1, 4'd0,  32'h7004, 32'h0, 1'b1, 32'h0},    // R4
      '{2'd0, 2'd0, 3'd0, 5'd0,  1'b0, 3'd1, 4'd2,  2'd1, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R3 n=1 8b
      '{2'd0, 2'd2, 3'd2, 5'd0,  1'b0, 3'd0, 4'd2,  2'd1, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R1 lane
      '{2'd0, 2'd0, 3'd0, 5'd0,  1'b0, 3'd0, 4'd2,  2'd2, 4'd13, 32'h100,  32'h8, 1'b1, 32'h0},    // R5 sp
      '{2'd0, 2'd0, 3'd0, 5'd0,  1'b0, 3'd0, 4'd15, 2'd0, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R5 pc base
      '{2'd3, 2'd2, 3'd0, 5'd0,  1'b0, 3'd4, 4'd2,  2'd1, 4'd0,  32'h4008, 32'h0, 1'b1, 32'h0},    // R4
      '{2'd1, 2'd1, 3'd0, 5'd0,  1'b0, 3'd2, 4'd2,  2'd2, 4'd3,  32'h100,  32'hFFFFFFF0, 1'b0, 32'hF0}, // R9
      '{2'd0, 2'd1, 3'd3, 5'd31, 1'b0, 3'd1, 4'd2,  2'd0, 4'd0,  32'h0FFE, 32'h0, 1'b0, 32'h0FFE}, // R2 R3
      '{2'd0, 2'd3, 3'd0, 5'd0,  1'b0, 3'd0, 4'd2,  2'd1, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R1 size
      '{2'd0, 2'd0, 3'd0, 5'd0,  1'b0, 3'd0, 4'd2,  2'd3, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R5 mode
      '{2'd0, 2'd2, 3'd0, 5'd0,  1'b0, 3'd5, 4'd2,  2'd1, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R3 code
      '{2'd3, 2'd2, 3'd0, 5'd26, 1'b1, 3'd0, 4'd2,  2'd1, 4'd0,  32'h100,  32'h0, 1'b1, 32'h0},    // R2 stride
      '{2'd3, 2'd1, 3'd3, 5'd25, 1'b1, 3'd0, 4'd2,  2'd1, 4'd0,  32'h10,   32'h0, 1'b0, 32'h18},   // R2 R7
      '{2'd0, 2'd0, 3'd0, 5'd0,  1'b0, 3'd0, 4'd15, 2'd2, 4'd15, 32'h100,  32'h4, 1'b1, 32'h0}     // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_count = '0;
   logic [1:0]  req_esize = '0;
   logic [2:0]  req_lane = '0;
   logic [4:0]  req_first_reg = '0;
   logic        req_stride2 = 1'b0;
   logic [2:0]  req_align = '0;
   logic [3:0]  req_base_reg = '0;
   logic [1:0]  req_wb_mode = '0;
   logic [3:0]  req_off_reg = '0;
   logic [31:0] req_base = '0;
   logic [31:0] req_offset = '0;
   logic        busy;
   logic [4:0]  rf_rd_idx;
   logic [63:0] rf_rd_data;
   logic        mem_wr_valid;
   logic        mem_wr_ready = 1'b0;
   logic [31:0] mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic [3:0]  mem_wr_be;
   logic        done;
   logic        err;
   logic [31:0] new_base;

   int n_checks = 0;
   int n_fails = 0;

   always #10 clk = ~clk;

   function automatic logic [63:0] reg_image(input logic [4:0] idx);
      logic [63:0] v;
      for (int j = 0; j < 8; j++) v[j*8 +: 8] = 8'(int'(idx) * 8 + j) ^ 8'hA5;
      return v;
   endfunction

   assign rf_rd_data = reg_image(rf_rd_idx);

   lane_struct_store uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
      .req_esize(req_esize), .req_lane(req_lane), .req_first_reg(req_first_reg),
      .req_stride2(req_stride2), .req_align(req_align), .req_base_reg(req_base_reg),
      .req_wb_mode(req_wb_mode), .req_off_reg(req_off_reg), .req_base(req_base),
      .req_offset(req_offset), .busy(busy), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be), .done(done), .err(err),
      .new_base(new_base)
   );

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive_now(input vec_t v);
      req_count = v.cnt;  req_esize = v.esz;  req_lane = v.lane;
      req_first_reg = v.first; req_stride2 = v.s2; req_align = v.al;
      req_base_reg = v.breg; req_wb_mode = v.wb; req_off_reg = v.oreg;
      req_base = v.base; req_offset = v.off;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Collects the response from the negedge after acceptance; returns in the done/err cycle.
   task automatic drain(input vec_t v, input int seed, input logic [31:0] prev_nb);
      int nwr = 0;
      int guard = 0;
      logic fin = 1'b0;
      logic saw_err = 1'b0;
      int eb = 1 << v.esz;
      while (!fin && guard < 200) begin
         if (err) begin
            saw_err = 1'b1; fin = 1'b1;
         end else if (done) begin
            fin = 1'b1;
         end else begin
            if (mem_wr_valid) begin
               mem_wr_ready = ((guard + seed) % 3) != 0;
               if (mem_wr_ready) begin
                  logic [4:0]  r  = 5'(int'(v.first) + nwr * (v.s2 ? 2 : 1));
                  logic [63:0] rv = reg_image(r) >> (int'(v.lane) * eb * 8);
                  logic [31:0] xd = (eb == 4) ? rv[31:0] : (rv[31:0] & ((32'd1 << (eb * 8)) - 32'd1));
                  logic [31:0] xa = v.base + 32'(nwr * eb);
                  check(mem_wr_addr == xa, "R7 address", mem_wr_addr, xa);
                  check(mem_wr_data == xd, "R7 data", mem_wr_data, xd);
                  check(mem_wr_be == 4'((1 << eb) - 1), "R7 byte enables",
                        32'(mem_wr_be), 32'((1 << eb) - 1));
                  nwr++;
               end
            end else begin
               mem_wr_ready = 1'b0;
            end
            @(negedge clk);
            guard++;
         end
      end
      mem_wr_ready = 1'b0;
      check(fin, "R9 completion seen", 32'(fin), 32'd1);
      check(saw_err == v.xerr, "R6 error flag", 32'(saw_err), 32'(v.xerr));
      check(nwr == (v.xerr ? 0 : int'(v.cnt) + 1), "R7 write count", 32'(nwr),
            32'(v.xerr ? 0 : int'(v.cnt) + 1));
      if (v.xerr) check(new_base == prev_nb, "R6 base unchanged", new_base, prev_nb);
      else        check(new_base == v.xnb, "R9 new base", new_base, v.xnb);
   endtask

   initial begin
      #(20 * 100000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [31:0] nb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 R9 reset state
      check(!busy && !mem_wr_valid, "R10 reset idle", 32'({busy, mem_wr_valid}), 32'd0);
      check(!done && !err, "R9 reset pulses low", 32'({done, err}), 32'd0);
      check(new_base == 32'd0, "R9 reset base", new_base, 32'd0);

      for (int i = 0; i < NV; i++) begin
         nb = new_base;
         @(negedge clk);
         drive_now(VECS[i]);
         drain(VECS[i], i, nb);
      end

      // R10 R8: request held while busy and stalled is ignored
      begin
         vec_t a = '{2'd1, 2'd1, 3'd1, 5'd4, 1'b0, 3'd0, 4'd2, 2'd1, 4'd0, 32'h800, 32'h0, 1'b0, 32'h804};
         vec_t bad = '{2'd2, 2'd0, 3'd0, 5'd0, 1'b0, 3'd1, 4'd15, 2'd3, 4'd0, 32'h1, 32'h0, 1'b1, 32'h0};
         @(negedge clk);
         drive_now(a);
         req_count = bad.cnt; req_align = bad.al; req_base_reg = bad.breg;
         req_wb_mode = bad.wb; req_base = bad.base;
         req_valid = 1'b1;
         mem_wr_ready = 1'b0;
         for (int c = 0; c < 4; c++) begin
            check(!err, "R10 no error while busy", 32'(err), 32'd0);
            check(mem_wr_valid && busy, "R10 busy holding write", 32'({mem_wr_valid, busy}), 32'd3);
            check(mem_wr_addr == 32'h800, "R8 stalled address", mem_wr_addr, 32'h800);
            @(negedge clk);
         end
         req_valid = 1'b0;
         nb = new_base;
         drain(a, 1, nb);
      end

      // R11: new request offered in the done cycle
      begin
         vec_t b = '{2'd0, 2'd2, 3'd1, 5'd7, 1'b0, 3'd2, 4'd1, 2'd1, 4'd0, 32'h900, 32'h0, 1'b0, 32'h904};
         vec_t c = '{2'd2, 2'd1, 3'd2, 5'd8, 1'b1, 3'd0, 4'd1, 2'd2, 4'd5, 32'hA00, 32'h30, 1'b0, 32'hA30};
         vec_t d = '{2'd2, 2'd0, 3'd0, 5'd0, 1'b0, 3'd2, 4'd1, 2'd1, 4'd0, 32'hB00, 32'h0, 1'b1, 32'h0};
         @(negedge clk);
         drive_now(b);
         drain(b, 0, new_base);
         check(done, "R11 in done cycle", 32'(done), 32'd1);
         drive_now(c);
         drain(c, 2, 32'h904);
         check(done, "R11 in done cycle", 32'(done), 32'd1);
         drive_now(d);
         drain(d, 0, 32'hA30);
      end

      repeat (2) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule